// File: doc/BRIEF.md
# Bus Read Slave Interface

This block is the device side of a simple synchronous read bus. A bus master presents an address together with an address strobe, and both are set up before a rising clock edge. On that edge the block compares the address with its own fixed device address. A matching strobe starts a read. The block then waits as many cycles as needed for the device core to raise its data-available signal.

On the edge where data-available is seen, the block captures the core data into a holding register. For the next clock cycle it drives that value onto the bus and raises data-ready. It then returns to idle. The bus data lines are driven only during that reply cycle. The output-enable pin goes to the pad's three-state control, so other devices can share the lines the rest of the time.

Top module: `bus_read_slave`

## Requirements
- R1: A synchronous active-high reset returns the block to idle. After the reset edge, data_ready is 0, bus_data_oe is 0 and bus_data is 0, and a read that was waiting is abandoned.
- R2: A strobe whose address differs from DEV_ADDR is ignored. A core_avail that follows it produces no data_ready pulse.
- R3: After a matching strobe, the block waits any number of cycles for core_avail, and data_ready stays 0 throughout the wait.
- R4: When core_avail is sampled high during a wait, data_ready is 1 for exactly one clock, in the cycle after that edge.
- R5: During the data_ready cycle, bus_data equals the core_data value sampled on the edge where core_avail was seen, even if core_data changes afterwards.
- R6: bus_data_oe is 1 exactly when data_ready is 1. While bus_data_oe is 0, bus_data is 0.
- R7: A matching strobe presented during the reply cycle does not start a new read. The block goes back to idle after replying.
- R8: core_avail asserted while idle has no effect and produces no data_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Address driven by the master |
| addr_strobe | input | 1 | Address-valid strobe from the master |
| core_data | input | DATA_W | Read data from the device core |
| core_avail | input | 1 | Core signals that core_data is valid |
| bus_data | output | DATA_W | Read data to the bus, zero when not driving |
| bus_data_oe | output | 1 | Pad drive enable for bus_data |
| data_ready | output | 1 | One-cycle reply strobe to the master |

## Verification
The bench builds the block with a 12-bit address, a 16-bit data path and DEV_ADDR = 12'h5A3. With these values, random addresses almost never match by chance, so mismatched strobes come up often and have to be rejected. The 16-bit data also exposes any lane or capture-timing error in the holding register. Random wait lengths from zero to several cycles cover both the back-to-back reply and the long-wait reply.

// File: rtl/bus_read_slave.sv
module bus_read_slave #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              addr_strobe,
  input  logic [DATA_W-1:0] core_data,
  input  logic              core_avail,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_data_oe,
  output logic              data_ready
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RESP} state_t;

  state_t            state;
  logic [DATA_W-1:0] hold_q;
  logic              hit;

  assign hit = addr_strobe && (bus_addr == DEV_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      hold_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (hit) state <= S_WAIT;
        S_WAIT: if (core_avail) begin
          hold_q <= core_data;
          state  <= S_RESP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign data_ready  = (state == S_RESP);
  assign bus_data_oe = data_ready;
  assign bus_data    = bus_data_oe ? hold_q : '0;

endmodule

module bus_read_slave_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] core_data,
  input logic              core_avail,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_data_oe,
  input logic              data_ready
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!data_ready && !bus_data_oe));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    data_ready |=> !data_ready);

  assert_pulse_follows_avail_R4: assert property (@(posedge clk) disable iff (rst)
    data_ready |-> $past(core_avail));

  assert_captured_data_R5: assert property (@(posedge clk) disable iff (rst)
    data_ready |-> (bus_data == $past(core_data)));

  assert_drive_window_R6: assert property (@(posedge clk) disable iff (rst)
    bus_data_oe == data_ready);

  assert_quiet_lines_R6: assert property (@(posedge clk) disable iff (rst)
    !bus_data_oe |-> (bus_data == '0));

endmodule

bind bus_read_slave bus_read_slave_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/bus_read_slave_bench.sv
module bus_read_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam logic [AW-1:0] DEV = 12'h5A3;

  logic          clk = 0;
  logic          rst = 1;
  logic [AW-1:0] bus_addr = '0;
  logic          addr_strobe = 0;
  logic [DW-1:0] core_data = '0;
  logic          core_avail = 0;
  logic [DW-1:0] bus_data;
  logic          bus_data_oe;
  logic          data_ready;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  bus_read_slave #(.ADDR_W(AW), .DATA_W(DW), .DEV_ADDR(DEV)) u_bus_read_slave (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .addr_strobe(addr_strobe),
    .core_data(core_data), .core_avail(core_avail), .bus_data(bus_data),
    .bus_data_oe(bus_data_oe), .data_ready(data_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [AW-1:0] miss_addr(logic [AW-1:0] r);
    return (r == DEV) ? (r ^ 12'h001) : r;
  endfunction

  function automatic logic [DW+1:0] idle_view();
    return '0;
  endfunction

  task automatic check(string req, logic [DW+1:0] act, logic [DW+1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW+1:0] outs();
    return {data_ready, bus_data_oe, bus_data};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finish_run();
      end
    end
  end

  task automatic do_read(int wait_n, logic [DW-1:0] d, bit strobe_in_resp);
    @(negedge clk);
    bus_addr = DEV; addr_strobe = 1;
    @(negedge clk);
    addr_strobe = 0; bus_addr = $urandom;
    for (int i = 0; i < wait_n; i++) begin
      check("R3 wait", outs(), idle_view());
      addr_strobe = $urandom_range(0, 1);
      core_data = $urandom;
      @(negedge clk);
    end
    check("R3 wait", outs(), idle_view());
    addr_strobe = 0;
    core_avail = 1; core_data = d;
    @(negedge clk);
    core_avail = 0; core_data = ~d;
    check("R4/R5 reply", outs(), {2'b11, d});
    if (strobe_in_resp) begin
      bus_addr = DEV; addr_strobe = 1; core_avail = 1;
    end
    @(negedge clk);
    check("R4/R6 after reply", outs(), idle_view());
    if (strobe_in_resp) begin
      addr_strobe = 0; core_avail = 1;
      @(negedge clk);
      check("R7 strobe in reply ignored", outs(), idle_view());
      core_avail = 0;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst = 1;
    repeat (2) @(negedge clk);
    check("R1 reset state", outs(), idle_view());
    rst = 0;
    @(negedge clk);
    check("R1 after reset", outs(), idle_view());

    // R8: avail while idle
    core_avail = 1; core_data = 16'hBEEF;
    @(negedge clk);
    core_avail = 0;
    @(negedge clk);
    check("R8 idle avail", outs(), idle_view());

    // R2: mismatched strobe then avail
    bus_addr = miss_addr(DEV ^ 12'h800); addr_strobe = 1;
    @(negedge clk);
    addr_strobe = 0; core_avail = 1; core_data = 16'h1234;
    @(negedge clk);
    core_avail = 0;
    check("R2 mismatch", outs(), idle_view());
    @(negedge clk);
    check("R2 mismatch", outs(), idle_view());

    // directed reads
    do_read(0, 16'hA55A, 0);
    do_read(7, 16'h0001, 0);
    do_read(1, 16'hFFFF, 1);

    // R1: reset abandons a waiting read
    @(negedge clk);
    bus_addr = DEV; addr_strobe = 1;
    @(negedge clk);
    addr_strobe = 0; rst = 1;
    @(negedge clk);
    rst = 0; core_avail = 1; core_data = 16'h7777;
    check("R1 reset in wait", outs(), idle_view());
    @(negedge clk);
    core_avail = 0;
    check("R1 reset abandons read", outs(), idle_view());

    // random mix
    for (int n = 0; n < 40; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        bus_addr = miss_addr(AW'($urandom)); addr_strobe = 1;
        @(negedge clk);
        addr_strobe = 0; core_avail = 1;
        @(negedge clk);
        core_avail = 0;
        check("R2 random mismatch", outs(), idle_view());
      end
      do_read($urandom_range(0, 5), DW'($urandom), bit'($urandom_range(0, 1)));
    end

    finish_run();
  end
endmodule